// File: doc/BRIEF.md
# APB Write-to-FIFO Push Bridge

This block is an APB subordinate whose data address feeds a small synchronous queue. Each write to that address pushes the write data into the queue. A consumer downstream takes entries out through a valid/ready pair. When the queue has no free entry, the write does not fail and is not dropped. Instead the access stretches with PREADY low until the consumer frees a slot. On the edge that ends the transfer, the held write data is pushed and the transfer completes together.

A second address reports how many entries the queue holds, and it never stalls. Accesses to any other address complete at once with an error response. Backpressure therefore reaches software only as extra bus cycles. Each transfer produces exactly one entry, however long it waits.

Top module: `apbq_bridge`

## Requirements
- R1: After reset, out_valid is low and a read of the status address (offset 0x4) returns a fill count of 0.
- R2: A write to the data address (offset 0x0) while the queue is not full completes in its first access cycle (zero wait states) with pslverr low, and pushes pwdata as one entry.
- R3: While the queue is full, a data-address write holds pready low and pushes nothing. A pop that frees a slot removes fullness on that edge, and the write completes and pushes on the following edge. A write that enters its access phase with the queue full therefore waits one cycle more than the number of access cycles that pass before the pop edge.
- R4: Each data-address write pushes exactly one entry, equal to the pwdata held through the transfer, no matter how many wait states it took.
- R5: A read of the status address completes with zero wait states and returns the current fill count in the low bits of prdata, with zeros above. This holds even while the queue is full.
- R6: A write to the status address completes with zero wait states and pslverr low, and changes nothing. A read of the data address completes with zero wait states, returns 0 and pops nothing.
- R7: A read or write to any address other than 0x0 and 0x4 completes with zero wait states, drives pslverr high on its completion cycle and changes nothing. Mapped accesses drive pslverr low.
- R8: out_valid is high exactly when the queue holds an entry. out_data shows the oldest entry and stays unchanged until it is popped (out_valid and out_ready high at an edge). Entries leave in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | AW (8) | APB byte address |
| pwdata | input | DW (32) | APB write data |
| pready | output | 1 | APB ready; low inserts a wait state |
| prdata | output | DW (32) | APB read data |
| pslverr | output | 1 | APB error on the completion cycle |
| out_valid | output | 1 | Queue holds an entry |
| out_ready | input | 1 | Consumer accepts the head entry |
| out_data | output | DW (32) | Oldest queued entry |

## Verification
A wrong fill count shows up within one transfer. A status read returns the wrong value, or a write stalls when the queue has room, or completes when it has none. Either effect appears as a wrong wait-state count on the very next data write. A pointer or storage fault cannot be seen until the queue is drained: the consumer receives entries out of order, duplicated or missing. For that reason every scenario ends by draining the queue and comparing against the bench's own list of pushed words. A stall that pushes early or twice leaves the count one high at the following status read.

// File: rtl/apbq_pkg.sv
package apbq_pkg;
    // Target of the current APB access after address decode.
    typedef enum logic [1:0] {
        TGT_IDLE = 2'd0,
        TGT_DATA = 2'd1,
        TGT_STAT = 2'd2,
        TGT_BAD  = 2'd3
    } apbq_tgt_e;
endpackage

// File: rtl/apbq_store.sv
module apbq_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_comb begin
            mem_d[i] = mem_q[i];
            if (wr_en && (wr_idx == PW'(i))) begin
                mem_d[i] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/apbq_fifo_ctl.sv
module apbq_fifo_ctl #(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop_ready,
    output logic          not_empty,
    output logic          full,
    output logic [CW-1:0] level,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx,
    output logic          pop
);
    localparam logic [PW-1:0] LAST_IDX  = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t st_d, st_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign not_empty = (st_q.cnt != '0);
    assign full      = (st_q.cnt == FULL_CNT);
    assign level     = st_q.cnt;
    assign wr_idx    = st_q.wr;
    assign rd_idx    = st_q.rd;
    assign pop       = not_empty && pop_ready;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = step(st_q.wr);
        end
        if (pop) begin
            st_d.rd = step(st_q.rd);
        end
        unique case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != FULL_CNT) || pop_ready);

    // R8
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // R3
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT) |-> !push);
endmodule

// File: rtl/apbq_apb_slave.sv
module apbq_apb_slave
    import apbq_pkg::*;
#(
    parameter int AW             = 8,
    parameter int DW             = 32,
    parameter int CW             = 3,
    parameter logic [AW-1:0] DATA_OFS = 'h0,
    parameter logic [AW-1:0] STAT_OFS = 'h4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic          full,
    input  logic [CW-1:0] level,
    output logic          pready,
    output logic [DW-1:0] prdata,
    output logic          pslverr,
    output logic          push
);
    apbq_tgt_e tgt;
    logic      access;
    logic      data_wr;

    always_comb begin
        if (!psel) begin
            tgt = TGT_IDLE;
        end else if (paddr == DATA_OFS) begin
            tgt = TGT_DATA;
        end else if (paddr == STAT_OFS) begin
            tgt = TGT_STAT;
        end else begin
            tgt = TGT_BAD;
        end
    end

    assign access  = psel && penable;
    assign data_wr = access && pwrite && (tgt == TGT_DATA);

    always_comb begin
        pready  = access && !(data_wr && full);
        push    = data_wr && !full;
        pslverr = access && (tgt == TGT_BAD);
        prdata  = '0;
        if (access && !pwrite && (tgt == TGT_STAT)) begin
            prdata = {{(DW-CW){1'b0}}, level};
        end
    end

    // R4
    push_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> pready);

    // R4
    push_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R4
    held_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !pready) |=> psel && penable && $stable(paddr) && $stable(pwdata));

    // R7
    err_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready && !push);
endmodule

// File: rtl/apbq_bridge.sv
module apbq_bridge #(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter logic [AW-1:0] DATA_OFS = 'h0,
    parameter logic [AW-1:0] STAT_OFS = 'h4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic          pready,
    output logic [DW-1:0] prdata,
    output logic          pslverr,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic          push;
    logic          pop;
    logic          full;
    logic [CW-1:0] level;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] rd_idx;

    apbq_apb_slave #(
        .AW(AW), .DW(DW), .CW(CW), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
    ) i_slave (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata),
        .full(full), .level(level),
        .pready(pready), .prdata(prdata), .pslverr(pslverr),
        .push(push)
    );

    apbq_fifo_ctl #(.DEPTH(DEPTH)) i_ctl (
        .clk(clk), .rst_n(rst_n),
        .push(push), .pop_ready(out_ready),
        .not_empty(out_valid), .full(full), .level(level),
        .wr_idx(wr_idx), .rd_idx(rd_idx), .pop(pop)
    );

    apbq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_idx(wr_idx), .wr_data(pwdata),
        .rd_idx(rd_idx), .rd_data(out_data)
    );

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data));

    // R8
    pop_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> out_valid);
endmodule

// File: tb/test_apbq_bridge.sv
module test_apbq_bridge;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_DATA = 8'h00;
    localparam logic [AW-1:0] A_STAT = 8'h04;
    localparam logic [AW-1:0] A_BAD  = 8'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic          pready;
    logic [DW-1:0] prdata;
    logic          pslverr;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [$];

    always #4 clk = ~clk;

    apbq_bridge i_apbq_bridge (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata),
        .pready(pready), .prdata(prdata), .pslverr(pslverr),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One APB transfer; returns wait states, read data and error flag.
    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int waits, output logic [DW-1:0] rd, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        waits = 0;
        forever begin
            #1;
            if (pready) break;
            waits++;
            @(negedge clk);
        end
        rd = prdata;
        err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic push_ok(input logic [DW-1:0] d, input string req);
        int w; logic [DW-1:0] r; logic e;
        xfer(1'b1, A_DATA, d, w, r, e);
        check(w == 0, req, w, 0);
        check(e == 1'b0, req, e, 0);
        model.push_back(d);
    endtask

    task automatic expect_level(input int exp, input string req);
        int w; logic [DW-1:0] r; logic e;
        xfer(1'b0, A_STAT, '0, w, r, e);
        check(w == 0 && e == 1'b0, req, w, 0);
        check(r == DW'(exp), req, r, exp);
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        out_ready = 1'b1;
        while (model.size() > 0) begin
            logic [DW-1:0] exp;
            exp = model.pop_front();
            #1;
            check(out_valid === 1'b1, req, out_valid, 1);
            check(out_data === exp, req, out_data, exp);
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        check(out_valid === 1'b0, req, out_valid, 0);
    endtask

    task automatic t_reset;
        #1;
        check(out_valid === 1'b0, "R1 valid", out_valid, 0);
        expect_level(0, "R1 level");
    endtask

    task automatic t_simple;
        push_ok(32'hA5A5_0001, "R2 write");
        #1;
        check(out_valid === 1'b1 && out_data === 32'hA5A5_0001, "R8 head", out_data, 32'hA5A5_0001);
        expect_level(1, "R5 level");
        drain("R8 order");
        expect_level(0, "R5 empty");
    endtask

    task automatic t_stall;
        int w; logic [DW-1:0] r; logic e;
        localparam int N = 5;
        push_ok(32'h1111_0000, "R2 fill");
        push_ok(32'h2222_0000, "R2 fill");
        push_ok(32'h3333_0000, "R2 fill");
        push_ok(32'h4444_0000, "R2 fill");
        expect_level(4, "R5 full");
        @(negedge clk);
        fork
            xfer(1'b1, A_DATA, 32'h5555_0000, w, r, e);
            begin
                // Pop edge lands in access cycle N-2; push follows one edge later.
                repeat (N) @(negedge clk);
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
        join
        void'(model.pop_front());
        model.push_back(32'h5555_0000);
        check(w == N - 1, "R3 waits", w, N - 1);
        check(e == 1'b0, "R3 err", e, 0);
        expect_level(4, "R4 one push");
        drain("R4 order");
    endtask

    task automatic t_status_write;
        int w; logic [DW-1:0] r; logic e;
        xfer(1'b1, A_STAT, 32'h55, w, r, e);
        check(w == 0 && e == 1'b0, "R6 stat wr", w, 0);
        expect_level(0, "R6 level");
        xfer(1'b0, A_DATA, '0, w, r, e);
        check(w == 0 && e == 1'b0, "R6 data rd", w, 0);
        check(r == '0, "R6 data rd", r, 0);
        check(out_valid === 1'b0, "R6 no push", out_valid, 0);
    endtask

    task automatic t_unmapped;
        int w; logic [DW-1:0] r; logic e;
        xfer(1'b1, A_BAD, 32'hDEAD, w, r, e);
        check(w == 0, "R7 wr waits", w, 0);
        check(e == 1'b1, "R7 wr err", e, 1);
        check(out_valid === 1'b0, "R7 no push", out_valid, 0);
        xfer(1'b0, A_BAD, '0, w, r, e);
        check(w == 0 && e == 1'b1, "R7 rd err", e, 1);
        expect_level(0, "R7 level");
    endtask

    task automatic t_full_side;
        int w; logic [DW-1:0] r; logic e;
        push_ok(32'h0000_00C1, "R2 fill");
        push_ok(32'h0000_00C2, "R2 fill");
        push_ok(32'h0000_00C3, "R2 fill");
        push_ok(32'h0000_00C4, "R2 fill");
        xfer(1'b1, A_BAD, 32'hBEEF, w, r, e);
        check(w == 0 && e == 1'b1, "R7 full bad", w, 0);
        xfer(1'b1, A_STAT, 32'h7, w, r, e);
        check(w == 0 && e == 1'b0, "R6 full stat", w, 0);
        expect_level(4, "R5 full level");
        drain("R8 full order");
    endtask

    initial begin
        #(8 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_simple();
        t_stall();
        t_status_write();
        t_unmapped();
        t_full_side();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule